// File: doc/BRIEF.md
# Message Interrupt Capture Queue

This block sits on the inbound path of a host bridge and watches memory writes arriving from the link. A write whose 64-bit address falls inside a programmed window is treated as a message-signalled interrupt. Its 32-bit payload and its full address are stored in an in-order hardware queue while capture is switched on. Writes outside the window, and all writes while capture is off, leave the block untouched.

Software drains the queue through a small register port. Each entry is released by a fixed three-read sequence. The payload register is read first, then the low address word, then the high address word, and the read of the high word retires the entry. A status register reports whether entries remain and whether any message was lost to a full queue. A level `pending` output follows the non-empty state so that an interrupt combiner can use it.

Top module: `msg_irq_capture`

## Requirements
- R1: After synchronous reset `pending` is 0, capture is off, the window base and size are 0, and the status register (offset 0x18) reads 0.
- R2: An inbound write (`in_valid` high) is queued only when bit 0 of the control register at 0x14 is 1 and base <= `in_addr` < base + size. The base is {0x08, 0x04} (high word, low word) and the size is the 32-bit register at 0x0C. All other inbound writes are ignored.
- R3: Entries come out in arrival order. Offset 0x20 returns the head payload, 0x24 returns address bits 31:0 and 0x28 returns address bits 63:32. Read data appears on `csr_rdata` in the cycle after the read strobe and holds until the next read.
- R4: The head entry is removed only by a read of 0x28 that directly follows a read of 0x20 and then a read of 0x24. A 0x24 read not preceded by 0x20, or a 0x28 read not preceded by 0x20 then 0x24, returns data but removes nothing.
- R5: Status bit 0 and `pending` are 1 exactly while the queue holds at least one entry. Both drop once the high address word of the last entry has been read in sequence.
- R6: The queue holds DEPTH entries (16 by default). A qualifying write that arrives while the queue is full is discarded and sets status bit 1.
- R7: Status bit 1 stays set until software writes the status register with bit 1 equal to 1. Writing 0 to that bit leaves it set.
- R8: Reads of 0x20, 0x24 or 0x28 while the queue is empty return 0 and leave queue and status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inbound write strobe |
| in_addr | input | 64 | Inbound write address |
| in_data | input | 32 | Inbound write payload |
| csr_wr_en | input | 1 | Register write strobe |
| csr_rd_en | input | 1 | Register read strobe |
| csr_addr | input | 8 | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data, one cycle after the strobe |
| pending | output | 1 | High while any captured message waits |

## Verification
The hardest condition to reach is a dropped message with the sticky loss flag set. That takes sixteen qualifying writes with no complete read sequence in between, then a seventeenth write. The stimulus fills the queue this way before any draining, then checks that the flag holds through a zero write and clears on a one write. It also checks that the sixteen surviving payloads drain in order with nothing from the extra write. Broken read sequences are driven on purpose, such as payload then high word, or a lone low word, to show that only the exact order retires an entry.

// File: rtl/msgcap_pkg.sv
package msgcap_pkg;

    localparam int ADDR_W = 64;
    localparam int DATA_W = 32;
    localparam int CSR_AW = 8;

    // register offsets; the drain sequence depends on the last three
    localparam logic [CSR_AW-1:0] OFS_BASE_LO = 8'h04;
    localparam logic [CSR_AW-1:0] OFS_BASE_HI = 8'h08;
    localparam logic [CSR_AW-1:0] OFS_SIZE    = 8'h0C;
    localparam logic [CSR_AW-1:0] OFS_CTRL    = 8'h14;
    localparam logic [CSR_AW-1:0] OFS_STATUS  = 8'h18;
    localparam logic [CSR_AW-1:0] OFS_PAYLOAD = 8'h20;
    localparam logic [CSR_AW-1:0] OFS_ADDR_LO = 8'h24;
    localparam logic [CSR_AW-1:0] OFS_ADDR_HI = 8'h28;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [ADDR_W-1:0] addr;
    } msg_entry_t;

    // progress through the three-read drain sequence
    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_GOT_PAY = 2'd1,
        SEQ_GOT_LO  = 2'd2
    } drain_seq_e;

    function automatic logic is_entry_reg(input logic [CSR_AW-1:0] a);
        return (a == OFS_PAYLOAD) || (a == OFS_ADDR_LO) || (a == OFS_ADDR_HI);
    endfunction

endpackage

// File: rtl/msgcap_window.sv
module msgcap_window
    import msgcap_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [DATA_W-1:0] size_i,
    output logic              hit_o
);
    // one extra bit keeps base + size from wrapping at the top of the space
    logic [ADDR_W:0] limit;

    always_comb begin
        limit = {1'b0, base_i} + {{(ADDR_W-DATA_W+1){1'b0}}, size_i};
        hit_o = (addr_i >= base_i) && ({1'b0, addr_i} < limit);
    end

endmodule

// File: rtl/msgcap_queue.sv
module msgcap_queue
    import msgcap_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  msg_entry_t       push_entry_i,
    input  logic             pop_i,
    output msg_entry_t       head_o,
    output logic             empty_o,
    output logic             full_o,
    output logic [$clog2(DEPTH):0] count_o
);
    localparam int PW = $clog2(DEPTH);
    localparam logic [PW:0] FULL_CNT = (PW+1)'(DEPTH);
    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

    msg_entry_t    slots [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [PW:0]   cnt;
    logic          do_push;
    logic          do_pop;

    assign do_push = push_i && (cnt != FULL_CNT);
    assign do_pop  = pop_i && (cnt != '0);

    always_ff @(posedge clk) begin
        if (do_push) begin
            slots[wr_ptr] <= push_entry_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign head_o  = slots[rd_ptr];
    assign empty_o = (cnt == '0);
    assign full_o  = (cnt == FULL_CNT);
    assign count_o = cnt;

endmodule

// File: rtl/msgcap_csr.sv
module msgcap_csr
    import msgcap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              csr_wr_en,
    input  logic              csr_rd_en,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic [DATA_W-1:0] csr_wdata,
    output logic [DATA_W-1:0] csr_rdata,
    input  msg_entry_t        head_i,
    input  logic              empty_i,
    input  logic              loss_set_i,
    output logic [ADDR_W-1:0] base_o,
    output logic [DATA_W-1:0] size_o,
    output logic              enable_o,
    output logic              loss_o,
    output logic              pop_o
);
    logic [DATA_W-1:0] base_lo_q;
    logic [DATA_W-1:0] base_hi_q;
    logic [DATA_W-1:0] size_q;
    logic              enable_q;
    logic              loss_q;
    drain_seq_e        seq_q;
    logic [DATA_W-1:0] rd_val;
    logic              entry_rd;

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            base_lo_q <= '0;
            base_hi_q <= '0;
            size_q    <= '0;
            enable_q  <= 1'b0;
        end else if (csr_wr_en) begin
            case (csr_addr)
                OFS_BASE_LO: base_lo_q <= csr_wdata;
                OFS_BASE_HI: base_hi_q <= csr_wdata;
                OFS_SIZE:    size_q    <= csr_wdata;
                OFS_CTRL:    enable_q  <= csr_wdata[0];
                default:     ;
            endcase
        end
    end

    // sticky loss flag: a new drop wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            loss_q <= 1'b0;
        end else if (loss_set_i) begin
            loss_q <= 1'b1;
        end else if (csr_wr_en && (csr_addr == OFS_STATUS) && csr_wdata[1]) begin
            loss_q <= 1'b0;
        end
    end

    // drain sequence tracking; reads on an empty queue leave it alone
    assign entry_rd = csr_rd_en && !empty_i && is_entry_reg(csr_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= SEQ_IDLE;
        end else if (entry_rd) begin
            case (csr_addr)
                OFS_PAYLOAD: seq_q <= SEQ_GOT_PAY;
                OFS_ADDR_LO: seq_q <= (seq_q == SEQ_GOT_PAY) ? SEQ_GOT_LO : SEQ_IDLE;
                default:     seq_q <= SEQ_IDLE;
            endcase
        end
    end

    assign pop_o = entry_rd && (csr_addr == OFS_ADDR_HI) && (seq_q == SEQ_GOT_LO);

    always_comb begin
        case (csr_addr)
            OFS_BASE_LO: rd_val = base_lo_q;
            OFS_BASE_HI: rd_val = base_hi_q;
            OFS_SIZE:    rd_val = size_q;
            OFS_CTRL:    rd_val = {{(DATA_W-1){1'b0}}, enable_q};
            OFS_STATUS:  rd_val = {{(DATA_W-2){1'b0}}, loss_q, !empty_i};
            OFS_PAYLOAD: rd_val = empty_i ? '0 : head_i.data;
            OFS_ADDR_LO: rd_val = empty_i ? '0 : head_i.addr[DATA_W-1:0];
            OFS_ADDR_HI: rd_val = empty_i ? '0 : head_i.addr[ADDR_W-1:DATA_W];
            default:     rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            csr_rdata <= '0;
        end else if (csr_rd_en) begin
            csr_rdata <= rd_val;
        end
    end

    assign base_o   = {base_hi_q, base_lo_q};
    assign size_o   = size_q;
    assign enable_o = enable_q;
    assign loss_o   = loss_q;

endmodule

// File: rtl/msg_irq_capture.sv
module msg_irq_capture
    import msgcap_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    input  logic              csr_wr_en,
    input  logic              csr_rd_en,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic [DATA_W-1:0] csr_wdata,
    output logic [DATA_W-1:0] csr_rdata,
    output logic              pending
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic [ADDR_W-1:0] win_base;
    logic [DATA_W-1:0] win_size;
    logic              cap_enable;
    logic              win_hit;
    logic              accept;
    logic              q_push;
    logic              q_pop;
    logic              q_empty;
    logic              q_full;
    logic [CW-1:0]     q_count;
    logic              loss_set;
    logic              loss_flag;
    msg_entry_t        new_entry;
    msg_entry_t        q_head;

    msgcap_window u_window (
        .addr_i (in_addr),
        .base_i (win_base),
        .size_i (win_size),
        .hit_o  (win_hit)
    );

    assign accept    = cap_enable && win_hit;
    assign q_push    = in_valid && accept && !q_full;
    assign loss_set  = in_valid && accept && q_full;
    assign new_entry = '{data: in_data, addr: in_addr};

    msgcap_queue #(.DEPTH(DEPTH)) u_queue (
        .clk          (clk),
        .rst          (rst),
        .push_i       (q_push),
        .push_entry_i (new_entry),
        .pop_i        (q_pop),
        .head_o       (q_head),
        .empty_o      (q_empty),
        .full_o       (q_full),
        .count_o      (q_count)
    );

    msgcap_csr u_csr (
        .clk        (clk),
        .rst        (rst),
        .csr_wr_en  (csr_wr_en),
        .csr_rd_en  (csr_rd_en),
        .csr_addr   (csr_addr),
        .csr_wdata  (csr_wdata),
        .csr_rdata  (csr_rdata),
        .head_i     (q_head),
        .empty_i    (q_empty),
        .loss_set_i (loss_set),
        .base_o     (win_base),
        .size_o     (win_size),
        .enable_o   (cap_enable),
        .loss_o     (loss_flag),
        .pop_o      (q_pop)
    );

    assign pending = !q_empty;

endmodule

// File: rtl/msgcap_checker.sv
module msgcap_checker
    import msgcap_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic                     accept,
    input logic [$clog2(DEPTH):0]   count,
    input logic                     pending,
    input logic                     csr_rd_en,
    input logic                     csr_wr_en,
    input logic [CSR_AW-1:0]        csr_addr,
    input logic                     wdata_b1,
    input logic [DATA_W-1:0]        csr_rdata,
    input logic                     loss,
    input logic                     pop
);
    localparam logic [$clog2(DEPTH):0] FULL_CNT = ($clog2(DEPTH)+1)'(DEPTH);

    // R1: reset leaves the queue empty and the loss flag clear
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (count == '0) && !loss);

    // R2: occupancy can only grow from a qualifying inbound write
    a_r2_capture_gate: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && accept) |=> count <= $past(count));

    // R4: occupancy only shrinks on a high-word read
    a_r4_pop_on_hi_read: assert property (@(posedge clk) disable iff (rst)
        !(csr_rd_en && csr_addr == OFS_ADDR_HI) |=> count >= $past(count));

    // R5: pending output follows occupancy
    a_r5_pending_nonempty: assert property (@(posedge clk) disable iff (rst)
        pending == (count != '0));

    // R6: occupancy never exceeds the depth
    a_r6_depth_bound: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT);

    // R6: a qualifying write on a full queue raises the loss flag
    a_r6_drop_sets_loss: assert property (@(posedge clk) disable iff (rst)
        (in_valid && accept && count == FULL_CNT && !pop) |=> loss);

    // R7: loss flag holds until a write of one to its bit
    a_r7_loss_sticky: assert property (@(posedge clk) disable iff (rst)
        (loss && !(csr_wr_en && csr_addr == OFS_STATUS && wdata_b1)) |=> loss);

    // R8: entry registers read as zero on an empty queue
    a_r8_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
        (csr_rd_en && count == '0 && is_entry_reg(csr_addr)) |=> csr_rdata == '0);

endmodule

bind msg_irq_capture msgcap_checker #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .accept    (accept),
    .count     (q_count),
    .pending   (pending),
    .csr_rd_en (csr_rd_en),
    .csr_wr_en (csr_wr_en),
    .csr_addr  (csr_addr),
    .wdata_b1  (csr_wdata[1]),
    .csr_rdata (csr_rdata),
    .loss      (loss_flag),
    .pop       (q_pop)
);

// File: tb/tb_msg_irq_capture.sv
module tb_msg_irq_capture;

    localparam logic [63:0] BASE = 64'h0000_0001_FEE0_0000;
    localparam int NVEC = 8;
    // stimulus table: {address, payload, expected capture}
    localparam logic [96:0] VEC [NVEC] = '{
        {BASE + 64'h0,     32'd0,     1'b1},
        {BASE + 64'h14,    32'd5,     1'b1},
        {BASE + 64'h3C,    32'd15,    1'b1},
        {BASE + 64'hFFC,   32'hA5,    1'b1},
        {BASE + 64'h1000,  32'h77,    1'b0},
        {BASE - 64'h4,     32'h66,    1'b0},
        {64'h0000_0000_FEE0_0010, 32'h55, 1'b0},
        {BASE + 64'h800,   32'h3C,    1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_addr = '0;
    logic [31:0] in_data = '0;
    logic        csr_wr_en = 1'b0;
    logic        csr_rd_en = 1'b0;
    logic [7:0]  csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        pending;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    msg_irq_capture dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
        .in_data(in_data), .csr_wr_en(csr_wr_en), .csr_rd_en(csr_rd_en),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .pending(pending)
    );

    task automatic check(input logic ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_csr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_wr_en = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_wr_en = 1'b0;
    endtask

    task automatic rd_csr(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        csr_rd_en = 1'b1; csr_addr = a;
        @(negedge clk);
        d = csr_rdata;
        csr_rd_en = 1'b0;
    endtask

    task automatic inject(input logic [63:0] a, input logic [31:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_data = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain_one(input logic [31:0] exp_d, input logic [63:0] exp_a,
                             input string req);
        logic [31:0] v;
        rd_csr(8'h20, v); check(v == exp_d, req, v, exp_d);
        rd_csr(8'h24, v); check(v == exp_a[31:0], req, v, exp_a[31:0]);
        rd_csr(8'h28, v); check(v == exp_a[63:32], req, v, exp_a[63:32]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check(pending == 1'b0, "R1 pending", pending, 0);
        rd_csr(8'h18, v); check(v == 0, "R1 status", v, 0);
        rd_csr(8'h14, v); check(v == 0, "R1 enable", v, 0);
        rd_csr(8'h0C, v); check(v == 0, "R1 size", v, 0);

        // R8: empty reads give zero and change nothing
        rd_csr(8'h20, v); check(v == 0, "R8 payload empty", v, 0);
        rd_csr(8'h28, v); check(v == 0, "R8 addr hi empty", v, 0);
        rd_csr(8'h18, v); check(v == 0, "R8 status after empty reads", v, 0);

        wr_csr(8'h04, BASE[31:0]);
        wr_csr(8'h08, BASE[63:32]);
        wr_csr(8'h0C, 32'd4096);

        // R2: capture off, in-window write is ignored
        inject(BASE + 64'h8, 32'd2);
        check(pending == 1'b0, "R2 disabled drop", pending, 0);
        wr_csr(8'h14, 32'd1);

        // table walk: R2 window edges, R3 ordering
        for (int i = 0; i < NVEC; i++) inject(VEC[i][96:33], VEC[i][32:1]);
        check(pending == 1'b1, "R5 pending after captures", pending, 1);
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][0]) drain_one(VEC[i][32:1], VEC[i][96:33], "R3 table drain");
        end
        check(pending == 1'b0, "R2 out-of-window writes dropped", pending, 0);
        rd_csr(8'h18, v); check(v == 0, "R5 status after drain", v, 0);

        // R4: broken sequences do not retire the entry
        inject(BASE + 64'h24, 32'd9);
        rd_csr(8'h20, v);
        rd_csr(8'h28, v);
        check(pending == 1'b1, "R4 payload then hi keeps entry", pending, 1);
        rd_csr(8'h24, v);
        rd_csr(8'h28, v);
        check(pending == 1'b1, "R4 lone lo then hi keeps entry", pending, 1);
        drain_one(32'd9, BASE + 64'h24, "R4 full sequence");
        check(pending == 1'b0, "R5 pending falls on last pop", pending, 0);

        // R6: fill to sixteen, seventeenth dropped
        for (int i = 0; i < 17; i++) inject(BASE + 64'(4 * i), 32'(i + 100));
        rd_csr(8'h18, v); check(v == 32'd3, "R6 loss flag set", v, 3);
        // R7: writing zero keeps it, writing one clears it
        wr_csr(8'h18, 32'd0);
        rd_csr(8'h18, v); check(v == 32'd3, "R7 zero write keeps loss", v, 3);
        wr_csr(8'h18, 32'd2);
        rd_csr(8'h18, v); check(v == 32'd1, "R7 one write clears loss", v, 1);
        for (int i = 0; i < 16; i++) drain_one(32'(i + 100), BASE + 64'(4 * i), "R6 survivors");
        check(pending == 1'b0, "R6 extra write absent", pending, 0);
        rd_csr(8'h20, v); check(v == 0, "R8 payload after drain", v, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule